// File: doc/BRIEF.md
# SDIO Mailbox Interrupt Front End

This block is the byte-wide register and mailbox front end of an SDIO I/O function. It holds eight byte FIFOs, called lanes. Four transmit lanes carry bytes from the host to the device. Four receive lanes carry bytes from the device to the host. A host access carries a function select and a 17-bit byte offset. In function 1 the offset decodes either to a mailbox window or to a register page. In function 0 only the interrupt enable and pending registers exist.

The device side reaches the mailboxes through two valid/ready streams. A push stream fills the receive lanes. Its ready is low while the selected lane is full, and a byte offered without ready stays unaccepted. A pop stream drains the transmit lanes. Its valid is high while the selected lane is not empty, and a byte leaves only on a cycle where valid and ready are both high. The host port is a plain strobe port with no back-pressure. A write to a full transmit lane is dropped. A read from an empty receive lane returns 0x00.

Interrupt status is not latched. It is formed continuously from receive-lane occupancy and from three event-driven sub-sources (counter, CPU, error), each masked by its own enable. The result folds into a function-0 pending bit and then into a single registered card interrupt line. A four-byte non-destructive lookahead into receive lane 0 and a per-lane "four bytes available" flag let software size a frame before popping it.

Top module: `sdio_mbox_front`

## Requirements
- R1: A function-1 write to an offset below 0x400 pushes the data into transmit lane `offset[9:8]`. Writes to 0x800–0xFFF, 0x1000–0x17FF, 0x1800–0x1FFF and 0x2000–0x27FF push into lanes 0, 1, 2 and 3. Writes at 0x2800 or above push into lane 0. The device pop stream returns each lane's bytes in write order.
- R2: A function-1 read of the same windows pops the matching receive lane, using the same lane numbering as writes. A read from an empty lane returns 0x00 and changes nothing.
- R3: Each lane holds DEPTH bytes. A host write to a full transmit lane is dropped. `dev_rx_ready` is low while the selected receive lane is full, and a push offered then is not stored.
- R4: `cmd_done` is high for exactly the one cycle after a function-1 write to offset 0xFF, 0xFFF or 0x3FFF. It stays low after any other write and after any function-0 access.
- R5: Function-1 status register 0x400 bits 0–3 are 1 exactly while receive lanes 0–3 hold data. Bit 5 always reads 0.
- R6: A pulse on bit n of `evt_cnt`, `evt_cpu` or `evt_err` sets bit n of that source's sub-status, and the bit stays set. Status bit 4 is set when counter sub-status AND counter enable is non-zero. Bit 6 does the same for CPU sub-status and CPU enable. Bit 7 does the same for error sub-status and error enable.
- R7: Reads of 0x401, 0x402 and 0x403 return the CPU, error and counter sub-status bytes.
- R8: Offsets 0x418, 0x419, 0x41A and 0x41B are read/write enables for the combined status, CPU, error and counter sources. A new enable affects the status on the very next access.
- R9: Bit n of register 0x405 (n = 0–3) is 1 when receive lane n holds at least 4 bytes. Bits 7–4 read 0.
- R10: Reads of 0x408–0x40B return the bytes at positions 0–3 from the head of receive lane 0 without popping. The position wraps across the end of the storage.
- R11: Any function-1 read or write of 0x440 clears counter sub-status bit 0 and reads as 0x00. If a counter bit-0 event arrives in the same cycle, the event wins.
- R12: Function-0 offset 4 is a read/write enable byte. Offset 5 reads the pending byte, whose bit 1 is set when status AND combined enable is non-zero. All other pending bits read 0.
- R13: `card_irq` is a register. In the cycle after any change, it becomes 1 exactly when function-0 enable bit 0 is set and pending AND function-0 enable is non-zero.
- R14: Read data appears on `host_rdata` with `host_rvalid` high in the cycle after a read strobe. It reflects the state before that access takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_func | input | 1 | 0 = function 0, 1 = function 1 |
| host_addr | input | 17 | Byte offset within the function |
| host_wdata | input | 8 | Write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| host_rdata | output | 8 | Read data |
| cmd_done | output | 1 | One-cycle strobe after a write to the end of the lane-0 window |
| dev_tx_sel | input | 2 | Transmit lane selected for device pop |
| dev_tx_valid | output | 1 | Selected transmit lane has a byte |
| dev_tx_ready | input | 1 | Device takes the byte |
| dev_tx_data | output | 8 | Head byte of the selected transmit lane |
| dev_rx_sel | input | 2 | Receive lane selected for device push |
| dev_rx_valid | input | 1 | Device offers a byte |
| dev_rx_ready | output | 1 | Selected receive lane has room |
| dev_rx_data | input | 8 | Byte offered by the device |
| evt_cnt | input | 8 | Counter event pulses, one per sub-status bit |
| evt_cpu | input | 8 | CPU event pulses |
| evt_err | input | 8 | Error event pulses |
| card_irq | output | 1 | Card interrupt line |

## Verification
The embedded assertions check these properties on every cycle: a full lane does not grow on a push, and an empty lane stays empty on a pop. `cmd_done` and `host_rvalid` only ever follow the matching access. `card_irq` rises only when the master enable was set one cycle earlier. A counter acknowledge with no competing event leaves counter bit 0 clear. Only the directed scenarios can show that data moves correctly: which window reaches which lane, byte order through a lane, lookahead across the storage wrap, dropped bytes on a full lane, and the exact mask and enable combinations that raise each status and interrupt bit.

// File: rtl/sdio_mbox_pkg.sv
package sdio_mbox_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 17;
  localparam int LANES  = 4;
  localparam int PEEK_N = 4;

  // window boundaries in function 1
  localparam logic [ADDR_W-1:0] WIN_BASE_END = 17'h00400;
  localparam logic [ADDR_W-1:0] WIN_REGS_END = 17'h00800;
  localparam logic [ADDR_W-1:0] WIN_X0_END   = 17'h01000;
  localparam logic [ADDR_W-1:0] WIN_X1_END   = 17'h01800;
  localparam logic [ADDR_W-1:0] WIN_X2_END   = 17'h02000;
  localparam logic [ADDR_W-1:0] WIN_X3_END   = 17'h02800;

  // offsets whose write ends a lane-0 command block
  localparam logic [ADDR_W-1:0] END_A = 17'h000FF;
  localparam logic [ADDR_W-1:0] END_B = 17'h00FFF;
  localparam logic [ADDR_W-1:0] END_C = 17'h03FFF;

  // function-1 register page
  localparam logic [ADDR_W-1:0] R_STAT    = 17'h00400;
  localparam logic [ADDR_W-1:0] R_CPU_ST  = 17'h00401;
  localparam logic [ADDR_W-1:0] R_ERR_ST  = 17'h00402;
  localparam logic [ADDR_W-1:0] R_CNT_ST  = 17'h00403;
  localparam logic [ADDR_W-1:0] R_DEEP    = 17'h00405;
  localparam logic [ADDR_W-1:0] R_LOOK0   = 17'h00408;
  localparam logic [ADDR_W-1:0] R_LOOK1   = 17'h00409;
  localparam logic [ADDR_W-1:0] R_LOOK2   = 17'h0040A;
  localparam logic [ADDR_W-1:0] R_LOOK3   = 17'h0040B;
  localparam logic [ADDR_W-1:0] R_EN_ALL  = 17'h00418;
  localparam logic [ADDR_W-1:0] R_EN_CPU  = 17'h00419;
  localparam logic [ADDR_W-1:0] R_EN_ERR  = 17'h0041A;
  localparam logic [ADDR_W-1:0] R_EN_CNT  = 17'h0041B;
  localparam logic [ADDR_W-1:0] R_CNT_ACK = 17'h00440;

  // function-0 registers
  localparam logic [ADDR_W-1:0] F0_EN   = 17'h00004;
  localparam logic [ADDR_W-1:0] F0_PEND = 17'h00005;

  // status bit positions
  localparam int ST_CNT_BIT = 4;
  localparam int ST_CPU_BIT = 6;
  localparam int ST_ERR_BIT = 7;
  localparam int PEND_F1_BIT = 1;

  // enable write selectors
  localparam int EN_ALL = 0;
  localparam int EN_CPU = 1;
  localparam int EN_ERR = 2;
  localparam int EN_CNT = 3;

  typedef enum logic {TGT_MBOX = 1'b0, TGT_REGS = 1'b1} tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [1:0] lane;
    logic       last_byte;
  } win_t;

endpackage

// File: rtl/mbox_window_decode.sv
module mbox_window_decode
  import sdio_mbox_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output win_t              win
);

  always_comb begin
    win.tgt       = TGT_MBOX;
    win.lane      = 2'd0;
    win.last_byte = (addr == END_A) || (addr == END_B) || (addr == END_C);
    if (addr < WIN_BASE_END) begin
      win.lane = addr[9:8];
    end else if (addr < WIN_REGS_END) begin
      win.tgt = TGT_REGS;
    end else if (addr < WIN_X0_END) begin
      win.lane = 2'd0;
    end else if (addr < WIN_X1_END) begin
      win.lane = 2'd1;
    end else if (addr < WIN_X2_END) begin
      win.lane = 2'd2;
    end else if (addr < WIN_X3_END) begin
      win.lane = 2'd3;
    end else begin
      win.lane = 2'd0;
    end
  end

endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 512,
  parameter int PEEK  = 4,
  parameter int W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [W-1:0]              wdata,
  input  logic                      pop,
  output logic [W*PEEK-1:0]         peek,
  output logic [$clog2(DEPTH):0]    level
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          empty, full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar k = 0; k < PEEK; k++) begin : g_peek
    logic [LW-1:0] raw;
    logic [AW-1:0] idx;
    assign raw = {1'b0, rp} + LW'(k);
    assign idx = (raw >= LW'(DEPTH)) ? AW'(raw - LW'(DEPTH)) : AW'(raw);
    assign peek[W*k +: W] = mem[idx];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == LW'(DEPTH))) else $error("full lane changed on push"); // R3

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == '0)) else $error("empty lane changed on pop"); // R2

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import sdio_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  rx_busy,
  input  logic [BYTE_W-1:0] evt_cnt,
  input  logic [BYTE_W-1:0] evt_cpu,
  input  logic [BYTE_W-1:0] evt_err,
  input  logic              cnt_clr0,
  input  logic [3:0]        en_we,
  input  logic              f0_en_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] f1_stat,
  output logic [BYTE_W-1:0] cpu_st,
  output logic [BYTE_W-1:0] err_st,
  output logic [BYTE_W-1:0] cnt_st,
  output logic [BYTE_W-1:0] f1_en,
  output logic [BYTE_W-1:0] cpu_en,
  output logic [BYTE_W-1:0] err_en,
  output logic [BYTE_W-1:0] cnt_en,
  output logic [BYTE_W-1:0] f0_en,
  output logic [BYTE_W-1:0] f0_pend,
  output logic              card_irq
);

  logic irq_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_st <= '0;
      err_st <= '0;
      cnt_st <= '0;
    end else begin
      cpu_st <= cpu_st | evt_cpu;
      err_st <= err_st | evt_err;
      cnt_st <= (cnt_st & ~{{(BYTE_W-1){1'b0}}, cnt_clr0}) | evt_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f1_en  <= '0;
      cpu_en <= '0;
      err_en <= '0;
      cnt_en <= '0;
      f0_en  <= '0;
    end else begin
      if (en_we[EN_ALL]) f1_en  <= wdata;
      if (en_we[EN_CPU]) cpu_en <= wdata;
      if (en_we[EN_ERR]) err_en <= wdata;
      if (en_we[EN_CNT]) cnt_en <= wdata;
      if (f0_en_we)      f0_en  <= wdata;
    end
  end

  always_comb begin
    f1_stat                = '0;
    f1_stat[LANES-1:0]     = rx_busy;
    f1_stat[ST_CNT_BIT]    = |(cnt_st & cnt_en);
    f1_stat[ST_CPU_BIT]    = |(cpu_st & cpu_en);
    f1_stat[ST_ERR_BIT]    = |(err_st & err_en);
    f0_pend                = '0;
    f0_pend[PEND_F1_BIT]   = |(f1_stat & f1_en);
    irq_next               = f0_en[0] && |(f0_pend & f0_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) card_irq <= 1'b0;
    else        card_irq <= irq_next;
  end

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_irq) |-> $past(f0_en[0])) else $error("irq without master enable"); // R13

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f0_en[0]) |=> !card_irq) else $error("irq held after master off"); // R13

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr0 && !evt_cnt[0]) |=> !cnt_st[0]) else $error("counter bit 0 not cleared"); // R11

  AST_SUB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_st[0] || evt_cpu[0]) |=> cpu_st[0]) else $error("cpu sub-status lost"); // R6

endmodule

// File: rtl/sdio_mbox_front.sv
module sdio_mbox_front
  import sdio_mbox_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_we,
  input  logic        host_func,
  input  logic [16:0] host_addr,
  input  logic [7:0]  host_wdata,
  output logic        host_rvalid,
  output logic [7:0]  host_rdata,
  output logic        cmd_done,
  input  logic [1:0]  dev_tx_sel,
  output logic        dev_tx_valid,
  input  logic        dev_tx_ready,
  output logic [7:0]  dev_tx_data,
  input  logic [1:0]  dev_rx_sel,
  input  logic        dev_rx_valid,
  output logic        dev_rx_ready,
  input  logic [7:0]  dev_rx_data,
  input  logic [7:0]  evt_cnt,
  input  logic [7:0]  evt_cpu,
  input  logic [7:0]  evt_err,
  output logic        card_irq
);

  localparam int LW = $clog2(DEPTH) + 1;

  win_t win;
  logic f0_acc, mb_hit, reg_hit;

  mbox_window_decode u_dec (
    .addr (host_addr),
    .win  (win)
  );

  assign f0_acc  = host_valid & ~host_func;
  assign mb_hit  = host_valid & host_func & (win.tgt == TGT_MBOX);
  assign reg_hit = host_valid & host_func & (win.tgt == TGT_REGS);

  logic [BYTE_W-1:0]        tx_head [LANES];
  logic [BYTE_W-1:0]        rx_head [LANES];
  logic [LANES-1:0]         tx_empty, rx_empty, rx_full, rx_deep;
  logic [BYTE_W*PEEK_N-1:0] look_bytes;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_push, tx_pop, rx_push, rx_pop;

    assign tx_push = mb_hit & host_we & (win.lane == 2'(g));
    assign rx_pop  = mb_hit & ~host_we & (win.lane == 2'(g));
    assign tx_pop  = dev_tx_ready & (dev_tx_sel == 2'(g));
    assign rx_push = dev_rx_valid & (dev_rx_sel == 2'(g));

    mbox_fifo #(.DEPTH(DEPTH), .PEEK(1), .W(BYTE_W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (host_wdata),
      .pop   (tx_pop),
      .peek  (tx_head[g]),
      .level (tx_lvl)
    );

    if (g == 0) begin : g_look
      mbox_fifo #(.DEPTH(DEPTH), .PEEK(PEEK_N), .W(BYTE_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (dev_rx_data),
        .pop   (rx_pop),
        .peek  (look_bytes),
        .level (rx_lvl)
      );
      assign rx_head[g] = look_bytes[BYTE_W-1:0];
    end else begin : g_plain
      mbox_fifo #(.DEPTH(DEPTH), .PEEK(1), .W(BYTE_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (dev_rx_data),
        .pop   (rx_pop),
        .peek  (rx_head[g]),
        .level (rx_lvl)
      );
    end

    assign tx_empty[g] = (tx_lvl == '0);
    assign rx_empty[g] = (rx_lvl == '0);
    assign rx_full[g]  = (rx_lvl == LW'(DEPTH));
    assign rx_deep[g]  = (rx_lvl >= LW'(PEEK_N));
  end

  assign dev_tx_valid = ~tx_empty[dev_tx_sel];
  assign dev_tx_data  = tx_head[dev_tx_sel];
  assign dev_rx_ready = ~rx_full[dev_rx_sel];

  // interrupt state
  logic [BYTE_W-1:0] f1_stat, cpu_st, err_st, cnt_st;
  logic [BYTE_W-1:0] f1_en, cpu_en, err_en, cnt_en, f0_en, f0_pend;
  logic [3:0]        en_we;
  logic              cnt_clr0, f0_en_we;

  assign en_we[EN_ALL] = reg_hit & host_we & (host_addr == R_EN_ALL);
  assign en_we[EN_CPU] = reg_hit & host_we & (host_addr == R_EN_CPU);
  assign en_we[EN_ERR] = reg_hit & host_we & (host_addr == R_EN_ERR);
  assign en_we[EN_CNT] = reg_hit & host_we & (host_addr == R_EN_CNT);
  assign cnt_clr0      = reg_hit & (host_addr == R_CNT_ACK);
  assign f0_en_we      = f0_acc & host_we & (host_addr == F0_EN);

  irq_aggregator u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_busy  (~rx_empty),
    .evt_cnt  (evt_cnt),
    .evt_cpu  (evt_cpu),
    .evt_err  (evt_err),
    .cnt_clr0 (cnt_clr0),
    .en_we    (en_we),
    .f0_en_we (f0_en_we),
    .wdata    (host_wdata),
    .f1_stat  (f1_stat),
    .cpu_st   (cpu_st),
    .err_st   (err_st),
    .cnt_st   (cnt_st),
    .f1_en    (f1_en),
    .cpu_en   (cpu_en),
    .err_en   (err_en),
    .cnt_en   (cnt_en),
    .f0_en    (f0_en),
    .f0_pend  (f0_pend),
    .card_irq (card_irq)
  );

  // read mux
  logic [BYTE_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (!host_func) begin
      case (host_addr)
        F0_EN:   rd_next = f0_en;
        F0_PEND: rd_next = f0_pend;
        default: rd_next = '0;
      endcase
    end else if (win.tgt == TGT_MBOX) begin
      rd_next = rx_empty[win.lane] ? '0 : rx_head[win.lane];
    end else begin
      case (host_addr)
        R_STAT:   rd_next = f1_stat;
        R_CPU_ST: rd_next = cpu_st;
        R_ERR_ST: rd_next = err_st;
        R_CNT_ST: rd_next = cnt_st;
        R_DEEP:   rd_next = {{(BYTE_W-LANES){1'b0}}, rx_deep};
        R_LOOK0:  rd_next = look_bytes[0*BYTE_W +: BYTE_W];
        R_LOOK1:  rd_next = look_bytes[1*BYTE_W +: BYTE_W];
        R_LOOK2:  rd_next = look_bytes[2*BYTE_W +: BYTE_W];
        R_LOOK3:  rd_next = look_bytes[3*BYTE_W +: BYTE_W];
        R_EN_ALL: rd_next = f1_en;
        R_EN_CPU: rd_next = cpu_en;
        R_EN_ERR: rd_next = err_en;
        R_EN_CNT: rd_next = cnt_en;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      cmd_done    <= 1'b0;
    end else begin
      host_rvalid <= host_valid & ~host_we;
      if (host_valid && !host_we) host_rdata <= rd_next;
      cmd_done    <= mb_hit & host_we & win.last_byte;
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(host_valid && host_we && host_func)) else $error("stray command strobe"); // R4

  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_valid && !host_we)) else $error("stray read valid"); // R14

endmodule

// File: tb/sdio_mbox_front_tb.sv
module sdio_mbox_front_tb;

  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_we = 1'b0, host_func = 1'b0;
  logic [16:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rvalid;
  logic [7:0]  host_rdata;
  logic        cmd_done;
  logic [1:0]  dev_tx_sel = '0;
  logic        dev_tx_valid;
  logic        dev_tx_ready = 1'b0;
  logic [7:0]  dev_tx_data;
  logic [1:0]  dev_rx_sel = '0;
  logic        dev_rx_valid = 1'b0;
  logic        dev_rx_ready;
  logic [7:0]  dev_rx_data = '0;
  logic [7:0]  evt_cnt = '0, evt_cpu = '0, evt_err = '0;
  logic        card_irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sdio_mbox_front #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .host_valid, .host_we, .host_func, .host_addr, .host_wdata,
    .host_rvalid, .host_rdata, .cmd_done, .dev_tx_sel, .dev_tx_valid,
    .dev_tx_ready, .dev_tx_data, .dev_rx_sel, .dev_rx_valid, .dev_rx_ready,
    .dev_rx_data, .evt_cnt, .evt_cpu, .evt_err, .card_irq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic host_wr(input logic f, input logic [16:0] a, input logic [7:0] d, output logic strobe);
    host_valid = 1'b1; host_we = 1'b1; host_func = f; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
    strobe = cmd_done;
  endtask

  task automatic host_rd(input logic f, input logic [16:0] a, output logic [7:0] d, output logic v);
    host_valid = 1'b1; host_we = 1'b0; host_func = f; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    d = host_rdata;
    v = host_rvalid;
  endtask

  task automatic wr1(input logic [16:0] a, input logic [7:0] d);
    logic s;
    host_wr(1'b1, a, d, s);
  endtask

  task automatic rd1(input logic [16:0] a, output logic [7:0] d);
    logic v;
    host_rd(1'b1, a, d, v);
  endtask

  task automatic dev_push(input logic [1:0] sel, input logic [7:0] d);
    dev_rx_sel = sel; dev_rx_data = d; dev_rx_valid = 1'b1;
    @(negedge clk);
    dev_rx_valid = 1'b0;
  endtask

  task automatic dev_pop(input logic [1:0] sel, output logic [7:0] d, output logic v);
    dev_tx_sel = sel;
    #1;
    v = dev_tx_valid;
    d = dev_tx_data;
    dev_tx_ready = 1'b1;
    @(negedge clk);
    dev_tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic v;
    chk("R13 card_irq after reset", card_irq, 0);
    chk("R1 tx valid after reset", dev_tx_valid, 0);
    chk("R3 rx ready after reset", dev_rx_ready, 1);
    host_rd(1'b1, 17'h400, d, v);
    chk("R5 status after reset", d, 8'h00);
    chk("R14 rvalid after read", v, 1);
    @(negedge clk);
    chk("R14 rvalid single cycle", host_rvalid, 0);
    host_rd(1'b0, 17'h5, d, v);
    chk("R12 pending after reset", d, 8'h00);
    rd1(17'h000, d);
    chk("R2 empty read returns zero", d, 8'h00);
  endtask

  task automatic t_look_wrap;
    logic [7:0] d; int errs = 0;
    for (int i = 0; i < DEPTH - 2; i++) dev_push(2'd0, 8'(i));
    for (int i = 0; i < DEPTH - 2; i++) begin
      rd1(17'h000, d);
      if (d !== 8'(i)) errs++;
    end
    chk("R2 lane0 order", errs, 0);
    for (int i = 0; i < 4; i++) dev_push(2'd0, 8'hA0 + 8'(i));
    rd1(17'h405, d);
    chk("R9 deep flag lane0", d, 8'h01);
    for (int k = 0; k < 4; k++) begin
      rd1(17'h408 + 17'(k), d);
      chk("R10 lookahead across wrap", d, 8'hA0 + 8'(k));
    end
    rd1(17'h408, d);
    chk("R10 lookahead does not pop", d, 8'hA0);
    rd1(17'h000, d);
    chk("R2 pop after lookahead", d, 8'hA0);
    rd1(17'h405, d);
    chk("R9 three bytes left", d, 8'h00);
    for (int i = 1; i < 4; i++) begin
      rd1(17'h000, d);
      chk("R2 drain lane0", d, 8'hA0 + 8'(i));
    end
  endtask

  task automatic t_tx_windows;
    logic [16:0] addrs [9] = '{17'h010, 17'h150, 17'h2A0, 17'h3FE, 17'h900,
                               17'h1200, 17'h1900, 17'h2100, 17'h3000};
    logic [1:0]  lanes [9] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
    logic [7:0] d; logic v;
    for (int i = 0; i < 9; i++) begin
      wr1(addrs[i], 8'h30 + 8'(i));
      dev_pop(lanes[i], d, v);
      chk("R1 window valid", v, 1);
      chk("R1 window lane data", d, 8'h30 + 8'(i));
      dev_pop(lanes[i], d, v);
      chk("R1 lane empty after pop", v, 0);
    end
  endtask

  task automatic t_cmd_done;
    logic s; logic [7:0] d; logic v;
    host_wr(1'b1, 17'h0FE, 8'h01, s);
    chk("R4 no strobe mid window", s, 0);
    host_wr(1'b1, 17'h0FF, 8'h02, s);
    chk("R4 strobe at 0xFF", s, 1);
    @(negedge clk);
    chk("R4 strobe one cycle", cmd_done, 0);
    host_wr(1'b1, 17'h0FFF, 8'h03, s);
    chk("R4 strobe at 0xFFF", s, 1);
    host_wr(1'b1, 17'h3FFF, 8'h04, s);
    chk("R4 strobe at 0x3FFF", s, 1);
    host_wr(1'b0, 17'h0FF, 8'h05, s);
    chk("R4 no strobe in function 0", s, 0);
    for (int i = 0; i < 4; i++) begin
      dev_pop(2'd0, d, v);
      chk("R1 command bytes in lane0", d, 8'h01 + 8'(i));
    end
  endtask

  task automatic t_full;
    logic [7:0] d; logic v; int errs = 0;
    for (int i = 0; i <= DEPTH; i++) wr1(17'h100, (i == DEPTH) ? 8'hEE : (8'(i) ^ 8'h5A));
    for (int i = 0; i < DEPTH; i++) begin
      dev_pop(2'd1, d, v);
      if (!v || d !== (8'(i) ^ 8'h5A)) errs++;
    end
    chk("R3 full tx lane keeps first bytes", errs, 0);
    dev_pop(2'd1, d, v);
    chk("R3 write to full tx lane dropped", v, 0);
    for (int i = 0; i < DEPTH; i++) dev_push(2'd3, 8'(i));
    dev_rx_sel = 2'd3; #1;
    chk("R3 rx ready low when full", dev_rx_ready, 0);
    dev_push(2'd3, 8'hEE);
    rd1(17'h400, d);
    chk("R5 status bit3 with data", d, 8'h08);
    errs = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd1(17'h2300, d);
      if (d !== 8'(i)) errs++;
    end
    chk("R2 extended window drains lane3", errs, 0);
    rd1(17'h300, d);
    chk("R3 push to full rx lane dropped", d, 8'h00);
  endtask

  task automatic t_rx_status;
    logic [7:0] d;
    dev_push(2'd1, 8'h61);
    dev_push(2'd2, 8'h62);
    rd1(17'h400, d);
    chk("R5 status lanes 1 and 2", d, 8'h06);
    rd1(17'h405, d);
    chk("R9 deep flags below four", d, 8'h00);
    rd1(17'h1000, d);
    chk("R2 extended read lane1", d, 8'h61);
    rd1(17'h200, d);
    chk("R2 base read lane2", d, 8'h62);
    rd1(17'h400, d);
    chk("R5 status clear after pops", d, 8'h00);
  endtask

  task automatic t_sub_sources;
    logic [7:0] d;
    evt_cpu = 8'h04; @(negedge clk); evt_cpu = 8'h00;
    rd1(17'h401, d);
    chk("R7 cpu sub-status", d, 8'h04);
    rd1(17'h400, d);
    chk("R6 cpu masked off", d, 8'h00);
    wr1(17'h419, 8'h04);
    rd1(17'h419, d);
    chk("R8 cpu enable readback", d, 8'h04);
    rd1(17'h400, d);
    chk("R6 cpu bit6", d, 8'h40);
    evt_err = 8'h80; @(negedge clk); evt_err = 8'h00;
    wr1(17'h41A, 8'h01);
    rd1(17'h402, d);
    chk("R7 error sub-status", d, 8'h80);
    rd1(17'h400, d);
    chk("R6 error mask mismatch", d, 8'h40);
    evt_cnt = 8'h03; @(negedge clk); evt_cnt = 8'h00;
    wr1(17'h41B, 8'h01);
    rd1(17'h41B, d);
    chk("R8 counter enable readback", d, 8'h01);
    rd1(17'h400, d);
    chk("R6 counter bit4", d, 8'h50);
    rd1(17'h440, d);
    chk("R11 ack reads zero", d, 8'h00);
    rd1(17'h403, d);
    chk("R11 read ack clears bit0", d, 8'h02);
    rd1(17'h400, d);
    chk("R6 counter bit4 gone", d, 8'h40);
    evt_cnt = 8'h01; @(negedge clk); evt_cnt = 8'h00;
    wr1(17'h440, 8'hFF);
    rd1(17'h403, d);
    chk("R11 write ack clears bit0", d, 8'h02);
    evt_cnt = 8'h01;
    rd1(17'h440, d);
    evt_cnt = 8'h00;
    rd1(17'h403, d);
    chk("R11 event wins over ack", d, 8'h03);
    wr1(17'h418, 8'hF0);
    rd1(17'h418, d);
    chk("R8 combined enable readback", d, 8'hF0);
    wr1(17'h418, 8'h00); wr1(17'h419, 8'h00); wr1(17'h41A, 8'h00); wr1(17'h41B, 8'h00);
    rd1(17'h400, d);
    chk("R6 all sub-sources masked", d, 8'h00);
  endtask

  task automatic t_card_irq;
    logic [7:0] d; logic v; logic s;
    dev_push(2'd0, 8'h77);
    wr1(17'h418, 8'h01);
    host_rd(1'b0, 17'h5, d, v);
    chk("R12 pending bit1", d, 8'h02);
    host_wr(1'b0, 17'h4, 8'h02, s);
    @(negedge clk);
    chk("R13 no irq without master", card_irq, 0);
    host_wr(1'b0, 17'h4, 8'h03, s);
    chk("R13 irq one cycle late", card_irq, 0);
    @(negedge clk);
    chk("R13 irq asserted", card_irq, 1);
    host_rd(1'b0, 17'h4, d, v);
    chk("R12 f0 enable readback", d, 8'h03);
    rd1(17'h000, d);
    chk("R2 pop interrupt byte", d, 8'h77);
    chk("R13 irq holds one cycle", card_irq, 1);
    @(negedge clk);
    chk("R13 irq drops after pop", card_irq, 0);
    host_rd(1'b0, 17'h5, d, v);
    chk("R12 pending clear", d, 8'h00);
    dev_push(2'd0, 8'h78);
    @(negedge clk);
    chk("R13 irq from new byte", card_irq, 1);
    wr1(17'h418, 8'h00);
    @(negedge clk);
    chk("R13 combined enable gates irq", card_irq, 0);
    rd1(17'h000, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_look_wrap();
    t_tx_windows();
    t_cmd_done();
    t_full();
    t_rx_status();
    t_sub_sources();
    t_card_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule